// File: doc/BRIEF.md
# Byte-Bus 16-bit Up/Down Counter

This block holds a 16-bit counter that a processor reaches through an 8-bit bus with two locations, one for the low byte and one for the high byte. An 8-bit holding register stands between the bus and the live high byte. Reading the low byte captures the matching high byte into that register, so a following high-byte read returns a consistent pair. Writing the high byte only fills the holding register. A later low-byte write then loads all sixteen bits on one clock edge.

The counter moves on a count-enable pulse chosen by a 3-bit source field. The source is either a free-running prescaler or an edge of an external pin, which first passes through a synchronizer. Two mode inputs set the behaviour on each enable: one picks counting down instead of up, and the other forces the count to zero. The block flags the maximum and zero values. A sticky flag records each upward wrap from 0xFFFF to zero, and a strobe input clears it.

Top module: `bus_counter16`

## Requirements
- R1: After reset the count, the holding register and the wrap flag are zero, `at_max` is 0 and `at_zero` is 1.
- R2: While `bus_addr` is 0, `bus_rdata` shows the live low byte, and a read strobe at address 0 copies the live high byte into the holding register. While `bus_addr` is 1, `bus_rdata` shows the holding register.
- R3: A write at address 1 changes only the holding register. A write at address 0 loads the count with {holding register, `bus_wdata`} on that clock edge.
- R4: With `src_sel` = 0 the count holds its value, and the bus still reads and writes it.
- R5: On each count enable the count becomes zero when `mode_clear` is 1. Otherwise it decrements by one when `mode_down` is 1 and increments by one when `mode_down` is 0.
- R6: A write at address 0 sets the count to the written value even when a count enable and a clear fall in the same cycle.
- R7: `src_sel` values 1, 2, 3, 4 and 5 give one count enable every 1, 8, 64, 256 and 1024 clocks, so any window of k·N clocks produces exactly k enables.
- R8: `src_sel` = 7 counts rising edges and `src_sel` = 6 counts falling edges of `ext_in`, after a two-flop synchronizer. Each edge gives exactly one enable.
- R9: `at_max` is 1 exactly when the count is 0xFFFF, and `at_zero` is 1 exactly when the count is 0x0000.
- R10: `wrap_flag` is set when an upward count moves 0xFFFF to 0x0000. A downward wrap does not set it. The flag stays set until a `wrap_clr` pulse, and a set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | 0 selects the low byte, 1 selects the holding register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| src_sel | input | 3 | Count-enable source: 0 stop, 1..5 prescale, 6 falling, 7 rising |
| ext_in | input | 1 | External count pin, asynchronous |
| mode_down | input | 1 | 1 counts down, 0 counts up |
| mode_clear | input | 1 | 1 clears the count on each enable |
| wrap_clr | input | 1 | Clears the wrap flag |
| at_max | output | 1 | Count equals 0xFFFF |
| at_zero | output | 1 | Count equals 0x0000 |
| wrap_flag | output | 1 | Sticky upward-wrap flag |

## Verification
Two pairs of functions can meet in one cycle. The first is a processor write to the low byte landing on an active count enable while the clear mode is also active. The bench runs with the divide-by-1 source, so an enable is present on every clock, then writes the low byte and stops the source on the next falling edge. A read-back must show exactly the written word, and neither zero nor the written word plus one. The second pair is a low-byte read that latches the high byte while the counter keeps running. The bench advances the count across a high-byte boundary between the low read and the high read, and the high read must still return the old high byte.

// File: rtl/bus_counter16.sv
module bus_counter16 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [2:0]    src_sel,
  input  logic          ext_in,
  input  logic          mode_down,
  input  logic          mode_clear,
  input  logic          wrap_clr,
  output logic          at_max,
  output logic          at_zero,
  output logic          wrap_flag
);
  localparam int CW    = 2 * DW;
  localparam int PRE_W = 10;

  logic [CW-1:0]    cnt_q;
  logic [DW-1:0]    hold_q;
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       sync_q;
  logic             tick, wr_lo, wr_hi, rd_lo, up_wrap;

  assign wr_lo = bus_wr && !bus_addr;
  assign wr_hi = bus_wr &&  bus_addr;
  assign rd_lo = bus_rd && !bus_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[1:0], ext_in};
    end

  always_comb
    case (src_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre_q[2:0];
      3'd3:    tick = &pre_q[5:0];
      3'd4:    tick = &pre_q[7:0];
      3'd5:    tick = &pre_q[9:0];
      3'd6:    tick = !sync_q[1] &&  sync_q[2];
      3'd7:    tick =  sync_q[1] && !sync_q[2];
      default: tick = 1'b0;
    endcase

  assign up_wrap = tick && !wr_lo && !mode_clear && !mode_down && at_max;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo) begin
      cnt_q <= {hold_q, bus_wdata};
    end else if (tick) begin
      if (mode_clear)     cnt_q <= '0;
      else if (mode_down) cnt_q <= cnt_q - 1'b1;
      else                cnt_q <= cnt_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     hold_q <= '0;
    else if (wr_hi) hold_q <= bus_wdata;
    else if (rd_lo) hold_q <= cnt_q[CW-1:DW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        wrap_flag <= 1'b0;
    else if (up_wrap)  wrap_flag <= 1'b1;
    else if (wrap_clr) wrap_flag <= 1'b0;

  assign bus_rdata = bus_addr ? hold_q : cnt_q[DW-1:0];
  assign at_max    = &cnt_q;
  assign at_zero   = ~|cnt_q;

  AST_TEMP_ON_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && !wr_hi |=> hold_q == $past(cnt_q[CW-1:DW])); // R2
  AST_LOW_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_q == {$past(hold_q), $past(bus_wdata)}); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == 3'd0 && !bus_wr |=> $stable(cnt_q)); // R4
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !bus_wr && !mode_clear && !mode_down |=> cnt_q == $past(cnt_q) + 1'b1); // R5
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(at_max) && at_zero && $past(tick && !bus_wr && !mode_down && !mode_clear) |-> wrap_flag); // R10
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_flag && !wrap_clr |=> wrap_flag); // R10
endmodule

// File: tb/bus_counter16_tb.sv
module bus_counter16_tb;
  logic       clk = 0, rst_n = 0;
  logic       bus_addr = 0, bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [2:0] src_sel = 0;
  logic       ext_in = 0, mode_down = 0, mode_clear = 0, wrap_clr = 0;
  logic       at_max, at_zero, wrap_flag;
  int         n_run = 0, n_fail = 0;

  bus_counter16 u_dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr16(input logic [15:0] v);
    wr(1, v[15:8]); wr(0, v[7:0]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(0, lo); rd(1, hi); v = {hi, lo};
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 at_zero", at_zero, 1); check("R1 at_max", at_max, 0);
    check("R1 wrap", wrap_flag, 0);
    rd(1, v[7:0]); check("R1 hold", v[7:0], 0);
    rd16(v); check("R1 count", v, 0);
  endtask

  task automatic t_bytes;
    logic [15:0] v; logic [7:0] b;
    wr16(16'h1234); rd16(v); check("R3 word write", v, 16'h1234);
    wr(1, 8'hAB); rd(1, b); check("R3 hold write", b, 8'hAB);
    rd16(v); check("R3 high write leaves count", v, 16'h1234);
    wr(1, 8'hAB); wr(0, 8'hCD); rd16(v); check("R3 load", v, 16'hABCD);
  endtask

  task automatic t_latch;
    logic [7:0] lo, hi;
    wr16(16'h12FE); rd(0, lo); check("R2 low", lo, 8'hFE);
    @(negedge clk); src_sel = 1; repeat (4) @(negedge clk); src_sel = 0;
    rd(1, hi); check("R2 latched high", hi, 8'h12);
    rd(0, lo); check("R2 low after run", lo, 8'h02);
    rd(1, hi); check("R2 new high", hi, 8'h13);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    wr16(16'h0777); repeat (20) @(negedge clk);
    rd16(v); check("R4 stopped", v, 16'h0777);
  endtask

  task automatic run(input logic [2:0] s, input int cyc);
    @(negedge clk); src_sel = s; repeat (cyc) @(negedge clk); src_sel = 0;
  endtask

  task automatic t_modes;
    logic [15:0] v;
    wr16(16'h0100); mode_down = 1; run(1, 3); rd16(v); check("R5 down", v, 16'h00FD);
    mode_down = 0; run(1, 5); rd16(v); check("R5 up", v, 16'h0102);
    mode_clear = 1; run(1, 2); rd16(v); check("R5 clear", v, 0);
    mode_clear = 0;
  endtask

  task automatic t_priority;
    logic [15:0] v;
    mode_clear = 1;
    @(negedge clk); src_sel = 1;
    wr(1, 8'h56);
    @(negedge clk); bus_addr = 0; bus_wdata = 8'h78; bus_wr = 1;
    @(negedge clk); bus_wr = 0; src_sel = 0;
    mode_clear = 0;
    rd16(v); check("R6 write over clear", v, 16'h5678);
    @(negedge clk); src_sel = 1; wr(1, 8'h11);
    @(negedge clk); bus_addr = 0; bus_wdata = 8'h22; bus_wr = 1;
    @(negedge clk); bus_wr = 0; src_sel = 0;
    rd16(v); check("R6 write over count", v, 16'h1122);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    int div [5] = '{1, 8, 64, 256, 1024};
    int k   [5] = '{20, 10, 5, 3, 2};
    for (int i = 0; i < 5; i++) begin
      wr16(0); run(3'(i + 1), div[i] * k[i]); rd16(v);
      check($sformatf("R7 div %0d", div[i]), v, k[i]);
    end
  endtask

  task automatic t_ext;
    logic [15:0] v;
    wr16(0); @(negedge clk); src_sel = 7;
    for (int i = 0; i < 4; i++) begin
      ext_in = 1; repeat (5) @(negedge clk);
      ext_in = 0; repeat (5) @(negedge clk);
    end
    src_sel = 0; rd16(v); check("R8 rising edges", v, 4);
    wr16(10); mode_down = 1; @(negedge clk); src_sel = 6;
    for (int i = 0; i < 3; i++) begin
      ext_in = 1; repeat (6) @(negedge clk);
      ext_in = 0; repeat (6) @(negedge clk);
    end
    src_sel = 0; mode_down = 0; rd16(v); check("R8 falling edges", v, 7);
  endtask

  task automatic t_flags;
    logic [15:0] v;
    wr16(16'hFFFF); #1 check("R9 at_max", at_max, 1); check("R9 not zero", at_zero, 0);
    run(1, 1); #1 check("R9 at_zero", at_zero, 1); check("R10 set", wrap_flag, 1);
    repeat (5) @(negedge clk); check("R10 sticky", wrap_flag, 1);
    @(negedge clk); wrap_clr = 1; @(negedge clk); wrap_clr = 0;
    check("R10 cleared", wrap_flag, 0);
    mode_down = 1; run(1, 1); mode_down = 0;
    #1 check("R9 down to max", at_max, 1); check("R10 down wrap", wrap_flag, 0);
    wr16(16'hFFFF); @(negedge clk); src_sel = 1; wrap_clr = 1;
    @(negedge clk); src_sel = 0; wrap_clr = 0;
    check("R10 set wins", wrap_flag, 1);
    rd16(v); check("R10 wrapped count", v, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset; t_bytes; t_latch; t_stop; t_modes;
    t_priority; t_prescale; t_ext; t_flags;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule